// File: doc/BRIEF.md
# Buffered Minimum / Maximum / Mean Scanner

This block keeps a local store of 32 unsigned words. The words are loaded one at a time through a simple write strobe. When a start pulse arrives, the block walks the store from the lowest index to the highest. It tracks the smallest and largest word it has seen and keeps a running total. When the walk ends, it raises a completion flag.

The three statistics are then read back through a combinational output bus. A two-bit selector chooses which one appears on the bus. Internally, a datapath holds the store, the index counter, the accumulators and the comparators. A small state machine sequences the datapath.

The store read is registered, so each word takes one fetch cycle and one update cycle. The data width is a parameter.

Top module: `mma_unit`

## Requirements
- R1: The store holds 32 words addressed by the 5-bit `wr_addr`. A word is written on a rising edge at which `wr_en` is high and no scan is running.
- R2: A `start` sampled high while idle begins a scan, and `done` is low after that edge. Once `done` is set, it stays high until the next accepted `start`.
- R3: The minimum starts each scan at all ones. It is replaced only by a word that is strictly smaller, so a store full of all-ones words reports all ones.
- R4: The maximum starts each scan at zero. It is replaced only by a word that is strictly larger, so a store full of zeros reports zero.
- R5: The mean equals the sum of all 32 words divided by 32, with the remainder dropped. The sum is held in DATA_W+5 bits and never wraps, so 32 all-ones words give a mean of all ones.
- R6: `rd_sel` chooses what `rd_data` shows: 2'b00 gives zero, 2'b01 the minimum, 2'b10 the maximum and 2'b11 the mean.
- R7: Count the edge that samples `start` as edge 1. `done` rises on edge 66, and `done` is only ever high while the controller is idle.
- R8: Writes presented while a scan is running are dropped. They affect neither the running scan nor any later scan.
- R9: A `start` presented while a scan is running is ignored. The running scan finishes at the same edge it would have without it.
- R10: After reset, `done` is low and every `rd_sel` value reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 5 | Store write index |
| wr_data | input | DATA_W | Word to store |
| start | input | 1 | Begin a scan when idle |
| done | output | 1 | Results valid, held until next start |
| rd_sel | input | 2 | Result selector |
| rd_data | output | DATA_W | Selected result |

## Verification
The embedded properties rest on three assumptions: `start` is only acted on while idle, the words are unsigned, and every scan visits exactly 32 entries between a clear and the completion flag. The properties on running totals and extremes assume nothing else changes the accumulators mid-scan. The stimulus loads the store only while the unit is idle, except where it deliberately injects writes and a second start in the middle of a scan to show they are refused. Results are read only after `done` rises, when the assumptions about a completed scan hold.

// File: rtl/mma_pkg.sv
package mma_pkg;

    localparam int unsigned DEPTH  = 32;
    localparam int unsigned ADDR_W = $clog2(DEPTH);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INIT  = 2'd1,
        ST_FETCH = 2'd2,
        ST_ACC   = 2'd3
    } mma_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_MIN  = 2'b01,
        SEL_MAX  = 2'b10,
        SEL_AVG  = 2'b11
    } mma_sel_e;

    typedef struct packed {
        logic clr;
        logic acc;
    } mma_ctl_t;

    function automatic logic is_last(input logic [ADDR_W-1:0] idx);
        return idx == ADDR_W'(DEPTH - 1);
    endfunction

endpackage

// File: rtl/mma_store.sv
module mma_store
    import mma_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem[waddr] <= wdata;
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/mma_datapath.sv
module mma_datapath
    import mma_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mma_ctl_t          ctl,
    input  logic [DATA_W-1:0] word,
    output logic [ADDR_W-1:0] idx,
    output logic              last,
    output logic [DATA_W-1:0] min_o,
    output logic [DATA_W-1:0] max_o,
    output logic [DATA_W-1:0] avg_o
);

    localparam int unsigned SUM_W = DATA_W + ADDR_W;

    logic [DATA_W-1:0] min_q, max_q;
    logic [SUM_W-1:0]  sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            min_q <= '0;
            max_q <= '0;
            sum_q <= '0;
            idx   <= '0;
        end else if (ctl.clr) begin
            min_q <= '1;
            max_q <= '0;
            sum_q <= '0;
            idx   <= '0;
        end else if (ctl.acc) begin
            sum_q <= sum_q + SUM_W'(word);
            if (word < min_q) min_q <= word;
            if (word > max_q) max_q <= word;
            idx <= idx + 1'b1;
        end
    end

    assign last  = is_last(idx);
    assign min_o = min_q;
    assign max_o = max_q;
    assign avg_o = sum_q[SUM_W-1:ADDR_W];

    AST_SUM_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        ctl.acc |=> sum_q >= $past(sum_q)); // R5
    AST_MIN_NONINC: assert property (@(posedge clk) disable iff (rst)
        ctl.acc |=> min_q <= $past(min_q)); // R3
    AST_MAX_NONDEC: assert property (@(posedge clk) disable iff (rst)
        ctl.acc |=> max_q >= $past(max_q)); // R4
    AST_CLEAR_SEEDS: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (min_q == '1 && max_q == '0 && sum_q == '0)); // R3

endmodule

// File: rtl/mma_ctrl.sv
module mma_ctrl
    import mma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     last,
    output mma_ctl_t ctl,
    output logic     busy,
    output logic     done
);

    mma_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_INIT;
            ST_INIT:  nxt = ST_FETCH;
            ST_FETCH: nxt = ST_ACC;
            ST_ACC:   nxt = last ? ST_IDLE : ST_FETCH;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start)    done <= 1'b0;
            else if (state == ST_ACC && last) done <= 1'b1;
        end
    end

    assign ctl.clr = (state == ST_INIT);
    assign ctl.acc = (state == ST_ACC);
    assign busy    = (state != ST_IDLE);

    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> state == ST_IDLE); // R7
    AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> !done); // R2
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start && done) |=> done); // R2
    AST_LAST_FINISHES: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACC && last) |=> (done && state == ST_IDLE)); // R7

endmodule

// File: rtl/mma_unit.sv
module mma_unit
    import mma_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    output logic              done,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    mma_ctl_t          ctl;
    logic              busy, last;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] word, min_v, max_v, avg_v;

    mma_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && !busy),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (idx),
        .rdata (word)
    );

    mma_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .word  (word),
        .idx   (idx),
        .last  (last),
        .min_o (min_v),
        .max_o (max_v),
        .avg_o (avg_v)
    );

    mma_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .last  (last),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    always_comb begin
        unique case (mma_sel_e'(rd_sel))
            SEL_MIN: rd_data = min_v;
            SEL_MAX: rd_data = max_v;
            SEL_AVG: rd_data = avg_v;
            default: rd_data = '0;
        endcase
    end

    AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (rst)
        done |-> min_v <= max_v); // R3
    AST_AVG_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        done |-> (avg_v >= min_v && avg_v <= max_v)); // R5

endmodule

// File: tb/test_mma_unit.sv
`timescale 1ns/1ps
module test_mma_unit;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst, wr_en, start, done;
    logic [4:0]    wr_addr;
    logic [DW-1:0] wr_data, rd_data;
    logic [1:0]    rd_sel;

    always #2 clk = ~clk;

    mma_unit #(.DATA_W(DW)) i_mma_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .done(done),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    typedef struct {
        string         req;
        logic [1:0]    sel;
        logic [DW-1:0] exp;
    } sb_item_t;

    sb_item_t      sb_q[$];
    int            checks = 0, fails = 0;
    logic [DW-1:0] model [32];
    logic          mon_active = 1'b0;
    int unsigned   lcg = 32'h1234_5678;

    task automatic check_val(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[23:16];
    endfunction

    // R1: load all 32 entries while idle
    task automatic load_store();
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 5'(a); wr_data = model[a];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: expected statistics from the bench copy of the store
    task automatic push_expected(string tag);
        int unsigned sum = 0;
        logic [DW-1:0] mn = '1, mx = '0;
        sb_item_t it;
        for (int a = 0; a < 32; a++) begin
            sum += model[a];
            if (model[a] < mn) mn = model[a];
            if (model[a] > mx) mx = model[a];
        end
        it.req = {"R6 sel00 ", tag}; it.sel = 2'b00; it.exp = '0;          sb_q.push_back(it);
        it.req = {"R3 min ", tag};   it.sel = 2'b01; it.exp = mn;          sb_q.push_back(it);
        it.req = {"R4 max ", tag};   it.sel = 2'b10; it.exp = mx;          sb_q.push_back(it);
        it.req = {"R5 avg ", tag};   it.sel = 2'b11; it.exp = DW'(sum / 32); sb_q.push_back(it);
    endtask

    // mode 0 plain, 1 inject writes mid-scan (R8), 2 inject start mid-scan (R9)
    task automatic run_scan(string tag, int mode);
        int cyc = 0;
        int lat = -1;
        push_expected(tag);
        @(negedge clk);
        start = 1'b1;
        while (cyc < 200) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start = 1'b0;
            wr_en = 1'b0;
            if (done) begin
                lat = cyc;
                break;
            end
            if (mode == 1 && cyc >= 4 && cyc < 40) begin
                wr_en = 1'b1; wr_addr = 5'(cyc - 4); wr_data = ~model[cyc - 4];
            end
            if (mode == 2 && cyc == 20) start = 1'b1;
        end
        start = 1'b0; wr_en = 1'b0;
        check_int({"R7 latency ", tag}, lat, 66);
        if (mode == 2) check_int({"R9 latency with extra start ", tag}, lat, 66);
        wait (sb_q.size() == 0 && !mon_active);
        repeat (6) @(negedge clk);
        check_val({"R2 done held ", tag}, DW'(done), DW'(1));
    endtask

    // monitor: pops expected items when results become valid
    initial begin
        sb_item_t it;
        forever begin
            @(posedge done);
            mon_active = 1'b1;
            while (sb_q.size() != 0) begin
                @(negedge clk);
                it = sb_q.pop_front();
                rd_sel = it.sel;
                #1;
                check_val(it.req, rd_data, it.exp);
            end
            mon_active = 1'b0;
        end
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; start = 1'b0;
        wr_addr = '0; wr_data = '0; rd_sel = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_val("R10 done after reset", DW'(done), DW'(0));
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            check_val("R10 read after reset", rd_data, '0);
        end

        for (int a = 0; a < 32; a++) model[a] = next_rand();
        load_store();
        run_scan("random", 0);

        for (int a = 0; a < 32; a++) model[a] = '0;
        load_store();
        run_scan("zeros", 0);

        for (int a = 0; a < 32; a++) model[a] = '1;
        load_store();
        run_scan("ones", 0);

        for (int a = 0; a < 32; a++) model[a] = DW'(a * 8 + 3);
        load_store();
        run_scan("ramp", 0);

        for (int a = 0; a < 32; a++) model[a] = next_rand() >> 1;
        load_store();
        run_scan("R8 writes during scan", 1);
        run_scan("R8 rerun unchanged store", 0);

        for (int a = 0; a < 32; a++) model[a] = DW'(255 - a * 5);
        load_store();
        run_scan("R9 extra start", 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule